// File: doc/BRIEF.md
# Keyed Clock Divider with Phase-Shifted Copy

This block divides an input clock by a programmable integer and produces two results: the divided waveform and a second copy of it that can be delayed by up to three input clocks, inverted, or gated off. It is modelled as a synchronous clock-enable generator: both outputs are levels that change only on rising edges of the input clock. The divided output is high for the first floor(N/2) input clocks of every N-clock period. At N = 1 it is held high.

Both settings are reached through a single 12-bit write port, and each write is guarded by a key. A divider write carries the key offset 0xAA0 plus the divisor. Any write that misses the key selects the largest ratio, divide-by-32. A phase write carries the key 0xAA in its upper byte. If that key is missing, the copy is turned on with no delay and no inversion. Settings change without stopping the output. A new divisor waits for the end of the running period, so no period is ever cut short. A status output rises once the divider is running after reset.

Top module: `keyed_clk_divider`

## Requirements
- R1: While rst_n is low, the divisor is 16, phase_out is 0 and running is 0. running goes to 1 at the first rising edge with rst_n high and stays there.
- R2: For a divisor N of 2 to 32, div_out is high for the first floor(N/2) clocks of every N-clock period and low for the rest. For N = 1, div_out is constantly high.
- R3: A write with wr_sel = 0 and wr_data[11:5] = 7'b1010101 (0xAA0 plus d, where d is 0 to 31) programs divisor code d. Code 0 means divide by 32, and codes 1 to 31 divide by the code.
- R4: A write with wr_sel = 0 whose bits 11:5 differ from 7'b1010101 programs code 0, which is divide by 32.
- R5: A programmed divisor takes effect only after the clock on which the running period reaches its last count. The period in progress completes with the old divisor.
- R6: A write with wr_sel = 1 and wr_data[11:4] = 0xAA loads the enable from bit 3, the invert from bit 2 and the shift from bits 1:0. These settings act from the next clock on.
- R7: A write with wr_sel = 1 and any other value in bits 11:4 sets enable to 1, invert to 0 and shift to 0.
- R8: phase_out equals div_out delayed by shift input clocks, XORed with invert, and forced to 0 while enable is 0. Before the first edge after reset, the delayed values read as 0. After reset, the phase copy is disabled.
- R9: While the divisor is 1, the invert control has no effect on phase_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_sel | input | 1 | Write target: 0 divider, 1 phase control |
| wr_data | input | 12 | Keyed write value |
| div_out | output | 1 | Divided waveform |
| phase_out | output | 1 | Delayed, optionally inverted copy of div_out |
| running | output | 1 | Divider running status |

## Verification
A write is captured on the rising edge where wr_en is high.

- A phase setting changes phase_out from the clock after that edge.
- A divisor first shapes div_out in the cycle after the next last-count edge.
- A shift of k shows the div_out level from k clocks earlier.
- running rises one edge after reset is released.

The bench applies inputs on the falling edge and samples the outputs on the next falling edge, after exactly one rising edge. On that same rising edge it advances its own period, delay and settings model. As a result, every comparison falls in the cycle where the expected value is due, with no extra allowance.

// File: rtl/kcd_pkg.sv
package kcd_pkg;

    // Target of a write on the shared port
    typedef enum logic {
        SEL_DIV   = 1'b0,
        SEL_PHASE = 1'b1
    } kcd_sel_e;

endpackage

// File: rtl/kcd_cfg_regs.sv
module kcd_cfg_regs #(
    parameter int                 DIV_W     = 5,
    parameter int                 SHIFT_W   = 2,
    parameter int                 FIELD_W   = 12,
    parameter logic [FIELD_W-1:0] DIV_KEY   = 12'hAA0,
    parameter logic [FIELD_W-1:0] PH_KEY    = 12'h0AA,
    parameter int                 RESET_DIV = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [FIELD_W-1:0] wr_data,
    output logic [DIV_W-1:0]   cfg_div,
    output logic               ph_en,
    output logic               ph_inv,
    output logic [SHIFT_W-1:0] ph_shift
);
    import kcd_pkg::*;

    localparam int PH_LSB = SHIFT_W + 2;        // lowest bit of the phase key
    localparam int PK_W   = FIELD_W - PH_LSB;   // phase key width

    typedef struct packed {
        logic [DIV_W-1:0]   div;
        logic               en;
        logic               inv;
        logic [SHIFT_W-1:0] shift;
    } cfg_t;

    cfg_t s_d, s_q;
    logic div_key_ok, ph_key_ok;

    always_comb begin
        div_key_ok = (wr_data[FIELD_W-1:DIV_W] == DIV_KEY[FIELD_W-1:DIV_W]);
        ph_key_ok  = (wr_data[FIELD_W-1:PH_LSB] == PH_KEY[PK_W-1:0]);
        s_d = s_q;
        if (wr_en) begin
            if (wr_sel == SEL_DIV) begin
                s_d.div = div_key_ok ? wr_data[DIV_W-1:0] : '0;
            end else if (ph_key_ok) begin
                s_d.en    = wr_data[SHIFT_W+1];
                s_d.inv   = wr_data[SHIFT_W];
                s_d.shift = wr_data[SHIFT_W-1:0];
            end else begin
                s_d.en    = 1'b1;
                s_d.inv   = 1'b0;
                s_d.shift = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.div   <= DIV_W'(RESET_DIV);
            s_q.en    <= 1'b0;
            s_q.inv   <= 1'b0;
            s_q.shift <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_div  = s_q.div;
    assign ph_en    = s_q.en;
    assign ph_inv   = s_q.inv;
    assign ph_shift = s_q.shift;

endmodule

// File: rtl/kcd_count.sv
module kcd_count #(
    parameter int DIV_W     = 5,
    parameter int RESET_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             div_out,
    output logic [DIV_W:0]   n_act,
    output logic [DIV_W-1:0] cnt,
    output logic             running
);
    localparam int             N_W     = DIV_W + 1;
    localparam logic [N_W-1:0] MAX_DIV = N_W'(1 << DIV_W);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [N_W-1:0]   n;
        logic             run;
    } cnt_t;

    cnt_t s_d, s_q;
    logic last;

    always_comb begin
        last    = ({1'b0, s_q.cnt} == s_q.n - 1'b1);
        s_d     = s_q;
        s_d.run = 1'b1;
        if (last) begin
            s_d.cnt = '0;
            s_d.n   = (cfg_div == '0) ? MAX_DIV : {1'b0, cfg_div};
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.n   <= N_W'(RESET_DIV);
            s_q.run <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign div_out = (s_q.n == N_W'(1)) || ({1'b0, s_q.cnt} < (s_q.n >> 1));
    assign n_act   = s_q.n;
    assign cnt     = s_q.cnt;
    assign running = s_q.run;

endmodule

// File: rtl/kcd_phase.sv
module kcd_phase #(
    parameter int DIV_W   = 5,
    parameter int SHIFT_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               div_out,
    input  logic [DIV_W:0]     n_act,
    input  logic               en,
    input  logic               inv,
    input  logic [SHIFT_W-1:0] shift,
    output logic               phase_out
);
    localparam int DEPTH = (1 << SHIFT_W) - 1;   // deepest delay in clocks

    logic [DEPTH-1:0] hist_d, hist_q;
    logic [DEPTH:0]   taps;
    logic             flip;

    always_comb begin
        taps      = {hist_q, div_out};     // taps[k]: div_out k clocks ago
        hist_d    = taps[DEPTH-1:0];
        flip      = inv && (n_act != (DIV_W+1)'(1));
        phase_out = en && (taps[shift] ^ flip);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

endmodule

// File: rtl/keyed_clk_divider.sv
module keyed_clk_divider #(
    parameter int          DIV_W     = 5,
    parameter int          SHIFT_W   = 2,
    parameter int          FIELD_W   = 12,
    parameter logic [11:0] DIV_KEY   = 12'hAA0,
    parameter logic [11:0] PH_KEY    = 12'h0AA,
    parameter int          RESET_DIV = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [11:0]  wr_data,
    output logic         div_out,
    output logic         phase_out,
    output logic         running
);
    logic [DIV_W-1:0]   cfg_div;
    logic               ph_en, ph_inv;
    logic [SHIFT_W-1:0] ph_shift;
    logic [DIV_W:0]     n_act;
    logic [DIV_W-1:0]   cnt;

    kcd_cfg_regs #(
        .DIV_W(DIV_W), .SHIFT_W(SHIFT_W), .FIELD_W(FIELD_W),
        .DIV_KEY(DIV_KEY), .PH_KEY(PH_KEY), .RESET_DIV(RESET_DIV)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cfg_div(cfg_div), .ph_en(ph_en),
        .ph_inv(ph_inv), .ph_shift(ph_shift)
    );

    kcd_count #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .div_out(div_out),
        .n_act(n_act), .cnt(cnt), .running(running)
    );

    kcd_phase #(.DIV_W(DIV_W), .SHIFT_W(SHIFT_W)) u_ph (
        .clk(clk), .rst_n(rst_n), .div_out(div_out), .n_act(n_act),
        .en(ph_en), .inv(ph_inv), .shift(ph_shift), .phase_out(phase_out)
    );

endmodule

// File: rtl/kcd_checker.sv
module kcd_checker #(
    parameter int          DIV_W   = 5,
    parameter int          SHIFT_W = 2,
    parameter logic [11:0] DIV_KEY = 12'hAA0,
    parameter logic [11:0] PH_KEY  = 12'h0AA
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               wr_sel,
    input logic [11:0]        wr_data,
    input logic               div_out,
    input logic               phase_out,
    input logic               running,
    input logic [DIV_W-1:0]   cfg_div,
    input logic [DIV_W:0]     n_act,
    input logic [DIV_W-1:0]   cnt,
    input logic               ph_en,
    input logic               ph_inv,
    input logic [SHIFT_W-1:0] ph_shift
);
    localparam int PH_LSB = SHIFT_W + 2;

    a_r1_running_rises: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> running);

    a_r2_div1_high: assert property (@(posedge clk) disable iff (!rst_n)
        (n_act == (DIV_W+1)'(1)) |-> div_out);

    a_r3_keyed_div: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[11:DIV_W] == DIV_KEY[11:DIV_W])
        |=> cfg_div == $past(wr_data[DIV_W-1:0]));

    a_r4_bad_div: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[11:DIV_W] != DIV_KEY[11:DIV_W])
        |=> cfg_div == '0);

    a_r5_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt} != n_act - 1'b1) |=> $stable(n_act));

    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt} == n_act - 1'b1) |=> cnt == '0);

    a_r7_bad_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && wr_data[11:PH_LSB] != PH_KEY[11-PH_LSB:0])
        |=> (ph_en && !ph_inv && ph_shift == '0));

    a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_en |-> !phase_out);

    a_r9_no_invert_div1: assert property (@(posedge clk) disable iff (!rst_n)
        (n_act == (DIV_W+1)'(1) && ph_en && ph_shift == '0) |-> phase_out);

endmodule

bind keyed_clk_divider kcd_checker #(
    .DIV_W(DIV_W), .SHIFT_W(SHIFT_W), .DIV_KEY(DIV_KEY), .PH_KEY(PH_KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .div_out(div_out), .phase_out(phase_out),
    .running(running), .cfg_div(cfg_div), .n_act(n_act), .cnt(cnt),
    .ph_en(ph_en), .ph_inv(ph_inv), .ph_shift(ph_shift)
);

// File: tb/sim_keyed_clk_divider.sv
`timescale 1ns/1ps
module sim_keyed_clk_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [11:0] wr_data = '0;
    logic        div_out, phase_out, running;

    keyed_clk_divider u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .div_out(div_out), .phase_out(phase_out),
        .running(running)
    );

    always #2.5 clk = ~clk;

    int    n_chk = 0, n_bad = 0;
    string tag = "R1";

    // reference state, built from the requirements
    int m_cnt = 0, m_n = 16, m_cfg = 16, m_sh = 0;
    bit m_en = 0, m_inv = 0, m_run = 0;
    bit h1 = 0, h2 = 0, h3 = 0;

    function automatic bit exp_div();
        return (m_n == 1) || (m_cnt < m_n / 2);
    endfunction

    function automatic bit exp_ph();
        bit src;
        case (m_sh)
            0: src = exp_div();
            1: src = h1;
            2: src = h2;
            default: src = h3;
        endcase
        return m_en && (src ^ (m_inv && m_n != 1));
    endfunction

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick(input bit we, input bit sel, input logic [11:0] d);
        bit cur;
        wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        cur = exp_div();
        h3 = h2; h2 = h1; h1 = cur;
        if (m_cnt == m_n - 1) begin
            m_cnt = 0;
            m_n   = (m_cfg == 0) ? 32 : m_cfg;
        end else begin
            m_cnt++;
        end
        if (we && !sel) m_cfg = (d[11:5] == 7'h55) ? int'(d[4:0]) : 0;
        if (we && sel) begin
            if (d[11:4] == 8'hAA) begin
                m_en = d[3]; m_inv = d[2]; m_sh = int'(d[1:0]);
            end else begin
                m_en = 1; m_inv = 0; m_sh = 0;
            end
        end
        m_run = 1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(tag, div_out, exp_div(), "div_out");
        chk(tag, phase_out, exp_ph(), "phase_out");
        chk("R1", running, m_run, "running");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, '0);
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", div_out, 1'b1, "div_out in reset (count 0 of 16)");
        chk("R1", phase_out, 1'b0, "phase_out in reset");
        chk("R1", running, 1'b0, "running in reset");
        rst_n = 1'b1;
        tag = "R1"; idle(3);
        tag = "R2"; idle(40);                     // default divide by 16
        tag = "R3"; tick(1, 0, 12'hAA5); idle(30);
        tag = "R3"; tick(1, 0, 12'hAA0); idle(70);    // code 0 -> 32
        tag = "R2"; tick(1, 0, 12'hAA2); idle(40);
        tag = "R4"; tick(1, 0, 12'hAC0); idle(70);
        tag = "R4"; tick(1, 0, 12'hAA7); idle(12);
        tag = "R4"; tick(1, 0, 12'h123); idle(70);
        tag = "R5"; tick(1, 0, 12'hAA3); idle(40);    // written mid 32-period
        tag = "R6"; tick(1, 1, 12'hAAA); idle(15);    // enable, shift 2
        tag = "R6"; tick(1, 1, 12'hAAF); idle(15);    // enable, invert, shift 3
        tag = "R8"; tick(1, 1, 12'hAA5); idle(10);    // disabled
        tag = "R7"; tick(1, 1, 12'h5F7); idle(15);
        chk("R7", phase_out, div_out, "bad key gives plain copy");
        tag = "R9"; tick(1, 1, 12'hAAC); tick(1, 0, 12'hAA1); idle(20);
        chk("R9", phase_out, 1'b1, "invert ignored at divide by 1");
        chk("R2", div_out, 1'b1, "divide by 1 held high");
        tag = "R8";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 12);
            if (r == 0)
                tick(1, 0, ($urandom % 6 == 0) ? 12'($urandom) : 12'hAA0 + 12'($urandom % 32));
            else if (r == 1)
                tick(1, 1, ($urandom % 5 == 0) ? 12'($urandom) : {8'hAA, 4'($urandom)});
            else
                tick(0, 0, '0);
        end
        report();
    end
endmodule